// File: doc/BRIEF.md
# Two-Contestant Quiz Buzzer Controller

This block referees one round of a two-player quiz. A host clear input and two contestant buttons arrive already debounced and active low. The first contestant whose button is seen pressed while the block is idle wins the round. The winner is latched, and every later press by either player is ignored until the host clears again.

Winning a round starts an answer countdown that begins at a configurable number of seconds. A seconds tick comes from dividing the system clock. When the count reaches zero, an active-low buzzer sounds for a fixed number of seconds and then goes quiet. The count stays at zero until the host clears.

The outputs are the winner's index and the remaining seconds, each as two BCD digits, ready for an external display driver. While the block is idle, every digit shows the code 15 so that the display can blank it.

Top module: `quiz_buzzer`

## Requirements
- R1: After reset, and on the cycle after clear_n is sampled low, all four digit outputs read 4'hF and buzz_n is high.
- R2: While idle, a low button sampled at a clock edge is accepted at that edge. From the next cycle, win_tens reads 0 and win_units reads the contestant index (1 for btn1_n, 2 for btn2_n).
- R3: If both buttons are sampled low at the same edge while idle, contestant 1 wins.
- R4: Once a winner is latched, neither button has any effect until the next clear. This includes the winner's button being held.
- R5: In the cycle after acceptance the remaining time reads ANSWER_SECS. It drops by one every TICK_CYCLES cycles, and the first drop comes TICK_CYCLES cycles after acceptance.
- R6: The remaining time is shown as a tens digit and a units digit in BCD, each 0 to 9, while a round is active.
- R7: When the remaining time reaches 0, buzz_n goes low in that same cycle. It stays low for exactly ALARM_SECS*TICK_CYCLES cycles and then returns high.
- R8: After reaching 0, the remaining time holds at 0 and the winner stays shown until clear.
- R9: Clear takes priority over everything, including a sounding buzzer and a press in the same cycle. The block returns to idle on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear_n | input | 1 | Host clear, active low, synchronous |
| btn1_n | input | 1 | Contestant 1 button, active low |
| btn2_n | input | 1 | Contestant 2 button, active low |
| win_tens | output | 4 | Winner index tens digit (0, or 15 when idle) |
| win_units | output | 4 | Winner index units digit (1 or 2, or 15 when idle) |
| secs_tens | output | 4 | Remaining seconds tens digit (15 when idle) |
| secs_units | output | 4 | Remaining seconds units digit (15 when idle) |
| buzz_n | output | 1 | Buzzer drive, active low |

## Verification
The bench builds the block with TICK_CYCLES set to 8 and keeps the defaults of 15 answer seconds and 5 alarm seconds. A full round from the win to the end of the buzzer then takes 160 cycles. Random clear and press patterns can therefore run many rounds to expiry, hit the buzzer in the middle of its sound, and hold at zero for long stretches. The fifteen-second start also puts both the tens and units digit paths to work, including the move from 10 to 9.

// File: rtl/quiz_buzzer.sv
module quiz_buzzer #(
  parameter int TICK_CYCLES = 50_000_000,
  parameter int ANSWER_SECS = 15,
  parameter int ALARM_SECS  = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear_n,
  input  logic       btn1_n,
  input  logic       btn2_n,
  output logic [3:0] win_tens,
  output logic [3:0] win_units,
  output logic [3:0] secs_tens,
  output logic [3:0] secs_units,
  output logic       buzz_n
);
  localparam int TW = $clog2(TICK_CYCLES + 1);
  localparam int SW = $clog2(ANSWER_SECS + 1);
  localparam int AW = $clog2(ALARM_SECS + 1);

  typedef enum logic [1:0] {IDLE, RUN, ALARM, DONE} phase_t;

  phase_t        phase;
  logic [1:0]    who;
  logic [SW-1:0] secs;
  logic [AW-1:0] alarm;
  logic [TW-1:0] tick;
  logic          tick_hit;
  logic          idle;
  logic [7:0]    s8;

  assign tick_hit = (tick == TW'(TICK_CYCLES - 1));
  assign idle     = (phase == IDLE);
  assign s8       = 8'(secs);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= IDLE;
      who   <= '0;
      secs  <= '0;
      alarm <= '0;
      tick  <= '0;
    end else if (!clear_n) begin
      phase <= IDLE;
      who   <= '0;
      secs  <= '0;
      alarm <= '0;
      tick  <= '0;
    end else begin
      case (phase)
        IDLE:
          if (!btn1_n || !btn2_n) begin
            who   <= !btn1_n ? 2'd1 : 2'd2;
            phase <= RUN;
            secs  <= SW'(ANSWER_SECS);
            tick  <= '0;
          end
        RUN:
          if (tick_hit) begin
            tick <= '0;
            secs <= secs - SW'(1);
            if (secs == SW'(1)) begin
              phase <= ALARM;
              alarm <= AW'(ALARM_SECS);
            end
          end else begin
            tick <= tick + TW'(1);
          end
        ALARM:
          if (tick_hit) begin
            tick  <= '0;
            alarm <= alarm - AW'(1);
            if (alarm == AW'(1)) phase <= DONE;
          end else begin
            tick <= tick + TW'(1);
          end
        default: ;
      endcase
    end
  end

  assign win_tens   = idle ? 4'hF : 4'd0;
  assign win_units  = idle ? 4'hF : {2'b00, who};
  assign secs_tens  = idle ? 4'hF : 4'(s8 / 8'd10);
  assign secs_units = idle ? 4'hF : 4'(s8 % 8'd10);
  assign buzz_n     = (phase != ALARM);
endmodule

// File: rtl/quiz_buzzer_chk.sv
module quiz_buzzer_chk #(
  parameter int ANSWER_SECS = 15
) (
  input logic       clk,
  input logic       rst_n,
  input logic       clear_n,
  input logic       btn1_n,
  input logic       btn2_n,
  input logic [3:0] win_tens,
  input logic [3:0] win_units,
  input logic [3:0] secs_tens,
  input logic [3:0] secs_units,
  input logic       buzz_n
);
  logic       idle;
  logic [7:0] sv;
  assign idle = (win_units == 4'hF);
  assign sv   = {4'd0, secs_tens} * 8'd10 + {4'd0, secs_units};

  p_clear_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_n |=> (win_units == 4'hF && win_tens == 4'hF && secs_units == 4'hF && secs_tens == 4'hF && buzz_n));

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && clear_n && (!btn1_n || !btn2_n)) |=> (sv == 8'(ANSWER_SECS)));

  p_tie_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && clear_n && !btn1_n && !btn2_n) |=> (win_units == 4'd1));

  p_lockout_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && clear_n) |=> $stable(win_units));

  p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && clear_n) |=> (sv == $past(sv) || sv == $past(sv) - 8'd1));

  p_bcd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |-> (secs_units <= 4'd9 && secs_tens <= 4'd9));

  p_buzz_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !buzz_n |-> (sv == 8'd0 && !idle));

  p_hold_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && clear_n && sv == 8'd0) |=> (sv == 8'd0));
endmodule

bind quiz_buzzer quiz_buzzer_chk #(.ANSWER_SECS(ANSWER_SECS)) u_chk (.*);

// File: tb/sim_quiz_buzzer.sv
`timescale 1ns/1ps
module sim_quiz_buzzer;
  localparam int T   = 8;
  localparam int ANS = 15;
  localparam int AL  = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clear_n = 1'b1, btn1_n = 1'b1, btn2_n = 1'b1;
  logic [3:0] win_tens, win_units, secs_tens, secs_units;
  logic buzz_n;

  int checks = 0, fails = 0;
  bit finished = 0;
  bit m_act = 0;
  int m_who = 0, m_n = 0;

  always #10 clk = ~clk;

  quiz_buzzer #(.TICK_CYCLES(T), .ANSWER_SECS(ANS), .ALARM_SECS(AL)) u0 (
    .clk(clk), .rst_n(rst_n), .clear_n(clear_n), .btn1_n(btn1_n), .btn2_n(btn2_n),
    .win_tens(win_tens), .win_units(win_units), .secs_tens(secs_tens),
    .secs_units(secs_units), .buzz_n(buzz_n));

  function automatic int exp_secs(int n);
    return (n >= ANS * T) ? 0 : ANS - n / T;
  endfunction

  function automatic bit exp_buzz(int n);
    return (n >= ANS * T && n < (ANS + AL) * T) ? 1'b0 : 1'b1;
  endfunction

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s at %0t: got %0d expected %0d", tag, $time, got, exp);
    end
  endtask

  task automatic compare();
    if (!m_act) begin
      chk("R1/R9 win_tens", win_tens, 15);
      chk("R1/R9 win_units", win_units, 15);
      chk("R1/R9 secs_tens", secs_tens, 15);
      chk("R1/R9 secs_units", secs_units, 15);
      chk("R1/R9 buzz_n", buzz_n, 1);
    end else begin
      chk("R2/R3/R4 win_tens", win_tens, 0);
      chk("R2/R3/R4 win_units", win_units, m_who);
      chk("R5/R6/R8 secs_tens", secs_tens, exp_secs(m_n) / 10);
      chk("R5/R6/R8 secs_units", secs_units, exp_secs(m_n) % 10);
      chk("R7 buzz_n", buzz_n, exp_buzz(m_n));
    end
  endtask

  task automatic cyc(bit c, bit b1, bit b2);
    clear_n = c; btn1_n = b1; btn2_n = b2;
    @(posedge clk);
    if (!c) m_act = 0;
    else if (!m_act) begin
      if (!b1) begin m_act = 1; m_who = 1; m_n = 0; end
      else if (!b2) begin m_act = 1; m_who = 2; m_n = 0; end
    end else m_n++;
    #5;
    compare();
  endtask

  task automatic finish_run();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    void'($urandom(32'd2024));
    #25;
    // R1: reset state
    compare();
    rst_n = 1'b1;
    #20;
    repeat (3) cyc(1, 1, 1);
    // R3: simultaneous press
    cyc(1, 0, 0);
    // R4: winner held, rival pressing
    repeat (10) cyc(1, 0, 1);
    repeat (10) cyc(1, 1, 0);
    // R5 R7 R8: run past expiry and buzzer, then hold
    for (int i = 0; i < 200; i++) cyc(1, 1, i % 3 != 0);
    // R9: clear, then contestant 2 wins
    cyc(0, 1, 1);
    cyc(1, 1, 0);
    for (int i = 0; i < ANS * T + 2 * T; i++) cyc(1, 1, 1);
    // R9: clear during buzzer with a press in the same cycle
    cyc(0, 0, 0);
    cyc(1, 1, 1);
    // random rounds
    for (int i = 0; i < 20000; i++) begin
      bit c, b1, b2;
      c  = ($urandom % 400) != 0;
      b1 = ($urandom % 10) != 0;
      b2 = ($urandom % 10) != 0;
      cyc(c, b1, b2);
    end
    finish_run();
  end

  initial begin
    #(100000 * 20);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end
endmodule